// File: doc/BRIEF.md
# Convolution Layer Engine

This block evaluates one two-dimensional convolution layer of a small image classifier in 16-bit fixed point (eight fraction bits). The input feature map, which may have several channels, sits in a local memory that is filled through a write port. Each filter's weights and bias sit in a per-filter register bank that is filled through a second write port. A one-cycle `start` pulse launches a pass over the whole map. The block emits one output beat per output position, and every beat carries the results of all filters side by side. A one-cycle `done` pulse closes the pass.

The schedule keeps the output position fixed. The engine walks the positions in raster order. At each position it feeds the window taps, one per cycle, into a single shared window-filter unit. That unit holds one private accumulator per filter, so every filter advances in the same cycle. Each accumulator is seeded with its filter's bias at the first tap of a position. It is kept in a register and written back only once, saturated, when the position's last tap arrives. No padding is applied and the stride is one, so the output map measures (IH−K+1) by (IW−K+1).

Top module: `conv_layer_engine`

## Requirements
- R1: After reset, `busy`, `done` and `out_valid` are all low.
- R2: A `start` pulse while idle begins a pass. `busy` is high from the next cycle through the cycle in which `done` is high, and low in the cycle after.
- R3: A pass produces exactly OH*OW output beats, where OH = IH−K+1 and OW = IW−K+1. The beats come in raster order: row index in the outer loop, column index in the inner loop. Each beat is tagged with `out_row` and `out_col`.
- R4: The image word for channel ch, row y, column x is at `img_addr` = (ch*IH + y)*IW + x. Weight tap (ch, kr, kc) of filter f is written with `coef_filt` = f and `coef_addr` = (ch*K + kr)*K + kc. `coef_addr` = CH*K*K writes the bias. All values are two's-complement with 8 fraction bits.
- R5: Filter f's value at output (r, c) is computed as follows. Start from bias·256. Add every image·weight product over the K×K×CH window whose top-left corner is (r, c). Arithmetic-shift the sum right by 8. Saturate the result to 16 bits.
- R6: All NF filters are reported in the same beat, with filter f's value in `out_data[16f+15:16f]`.
- R7: Every position starts again from its bias, and nothing carries over from the previous position or the previous pass. With all weights zero, every output equals its filter's bias.
- R8: A result above 32767 is reported as 32767, and a result below −32768 as −32768.
- R9: `done` is high for exactly one cycle, one cycle after the beat for the last position.
- R10: A `start` pulse while `busy` is high is ignored. The running pass neither restarts nor repeats beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass (accepted only while idle) |
| img_we | input | 1 | Image memory write enable |
| img_addr | input | $clog2(CH*IH*IW) | Image word address (R4 layout) |
| img_wdata | input | 16 | Image word, Q8.8 |
| coef_we | input | 1 | Coefficient write enable |
| coef_filt | input | max(1,$clog2(NF)) | Filter selected for the write |
| coef_addr | input | $clog2(CH*K*K+1) | Tap index, or CH*K*K for the bias |
| coef_wdata | input | 16 | Weight or bias, Q8.8 |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| out_valid | output | 1 | Output beat present |
| out_row | output | max(1,$clog2(OH)) | Row of the beat |
| out_col | output | max(1,$clog2(OW)) | Column of the beat |
| out_data | output | 16*NF | All filter results, filter f at bits 16f+15:16f |

## Verification
Every output of each pass is compared against an arithmetic model of the full window sum, and four weight patterns are used. Pseudo-random mixed-sign data and weights expose mistakes in tap addressing, channel stride and the right shift. With zero weights and distinct biases, each output must equal its bias, which separates seeding at each position from carry-over between positions. Full-scale operands with filters of opposite sign drive both saturation limits in the same beat. The pseudo-random pass is repeated with a stray `start` in the middle of the run, which shows whether the pass restarts or the beat count changes.

// File: rtl/conv_pkg.sv
package conv_pkg;

    localparam int DATA_W = 16;
    localparam int FRAC_W = 8;
    localparam int WIDE_W = 48;

    typedef logic signed [DATA_W-1:0] fx_t;
    typedef logic signed [WIDE_W-1:0] wide_t;

    typedef struct packed {
        logic valid;
        logic first;
        logic last;
        logic final_pos;
    } tap_ctl_t;

    function automatic wide_t bias_align(fx_t b);
        wide_t ext;
        ext = {{(WIDE_W-DATA_W){b[DATA_W-1]}}, b};
        return ext <<< FRAC_W;
    endfunction

    function automatic fx_t sat_fx(wide_t v);
        wide_t s;
        s = v >>> FRAC_W;
        if (s > wide_t'(32767))
            return fx_t'(16'sh7FFF);
        else if (s < -wide_t'(32768))
            return fx_t'(16'sh8000);
        else
            return fx_t'(s[DATA_W-1:0]);
    endfunction

    function automatic int wid(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/conv_fmap_mem.sv
module conv_fmap_mem
    import conv_pkg::*;
#(
    parameter int DEPTH = 72,
    localparam int AW = wid(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  fx_t           wdata,
    input  logic [AW-1:0] raddr,
    output fx_t           rdata
);
    fx_t mem_q [DEPTH];
    fx_t rd_q;

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH))
            mem_q[waddr] <= wdata;
        rd_q <= mem_q[raddr];
    end

    assign rdata = rd_q;
endmodule

// File: rtl/conv_coef_bank.sv
module conv_coef_bank
    import conv_pkg::*;
#(
    parameter int NF   = 4,
    parameter int TAPS = 18,
    localparam int FW  = wid(NF),
    localparam int TW  = $clog2(TAPS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [FW-1:0]        filt,
    input  logic [TW-1:0]        addr,
    input  fx_t                  wdata,
    input  logic [TW-1:0]        rd_tap,
    output logic [NF*DATA_W-1:0] w_flat,
    output logic [NF*DATA_W-1:0] b_flat
);
    for (genvar f = 0; f < NF; f++) begin : g_filt
        fx_t w_q [TAPS];
        fx_t b_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int t = 0; t < TAPS; t++) w_q[t] <= '0;
                b_q <= '0;
            end else if (we && (int'(filt) == f)) begin
                if (int'(addr) < TAPS)
                    w_q[addr] <= wdata;
                else if (int'(addr) == TAPS)
                    b_q <= wdata;
            end
        end

        assign w_flat[f*DATA_W +: DATA_W] = w_q[rd_tap];
        assign b_flat[f*DATA_W +: DATA_W] = b_q;
    end
endmodule

// File: rtl/conv_sched.sv
module conv_sched
    import conv_pkg::*;
#(
    parameter int IH = 6,
    parameter int IW = 6,
    parameter int CH = 2,
    parameter int K  = 3,
    localparam int OH   = IH - K + 1,
    localparam int OW   = IW - K + 1,
    localparam int TAPS = CH * K * K,
    localparam int AW   = wid(CH * IH * IW),
    localparam int RW   = wid(OH),
    localparam int CW   = wid(OW),
    localparam int TW   = $clog2(TAPS + 1),
    localparam int KW   = wid(K),
    localparam int HW   = wid(CH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          done_i,
    output logic          busy,
    output tap_ctl_t      iss_ctl,
    output logic [RW-1:0] iss_row,
    output logic [CW-1:0] iss_col,
    output logic [TW-1:0] iss_tap,
    output logic [AW-1:0] iss_addr
);
    logic          busy_q, run_q;
    logic [RW-1:0] row_q;
    logic [CW-1:0] col_q;
    logic [TW-1:0] tap_q;
    logic [KW-1:0] kr_q, kc_q;
    logic [HW-1:0] ch_q;

    logic tap_last, kc_last, kr_last, col_last, row_last;
    assign tap_last = (tap_q == TW'(TAPS - 1));
    assign kc_last  = (kc_q == KW'(K - 1));
    assign kr_last  = (kr_q == KW'(K - 1));
    assign col_last = (col_q == CW'(OW - 1));
    assign row_last = (row_q == RW'(OH - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            run_q  <= 1'b0;
            row_q  <= '0;
            col_q  <= '0;
            tap_q  <= '0;
            kr_q   <= '0;
            kc_q   <= '0;
            ch_q   <= '0;
        end else begin
            if (done_i) busy_q <= 1'b0;
            if (start && !busy_q) begin
                busy_q <= 1'b1;
                run_q  <= 1'b1;
                row_q  <= '0;
                col_q  <= '0;
                tap_q  <= '0;
                kr_q   <= '0;
                kc_q   <= '0;
                ch_q   <= '0;
            end else if (run_q) begin
                if (tap_last) begin
                    tap_q <= '0;
                    kr_q  <= '0;
                    kc_q  <= '0;
                    ch_q  <= '0;
                    if (col_last) begin
                        col_q <= '0;
                        if (row_last) run_q <= 1'b0;
                        else          row_q <= row_q + RW'(1);
                    end else begin
                        col_q <= col_q + CW'(1);
                    end
                end else begin
                    tap_q <= tap_q + TW'(1);
                    if (kc_last) begin
                        kc_q <= '0;
                        if (kr_last) begin
                            kr_q <= '0;
                            ch_q <= ch_q + HW'(1);
                        end else begin
                            kr_q <= kr_q + KW'(1);
                        end
                    end else begin
                        kc_q <= kc_q + KW'(1);
                    end
                end
            end
        end
    end

    int addr_i;
    always_comb begin
        addr_i = ((int'(ch_q) * IH) + int'(row_q) + int'(kr_q)) * IW
                 + int'(col_q) + int'(kc_q);
        iss_addr = AW'(addr_i);
    end

    assign busy              = busy_q;
    assign iss_ctl.valid     = run_q;
    assign iss_ctl.first     = (tap_q == '0);
    assign iss_ctl.last      = tap_last;
    assign iss_ctl.final_pos = tap_last && col_last && row_last;
    assign iss_row           = row_q;
    assign iss_col           = col_q;
    assign iss_tap           = tap_q;

    p_tap_range_r5: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (int'(tap_q) < TAPS));

    p_raster_step_r3: assert property (@(posedge clk) disable iff (rst)
        (run_q && tap_last && col_last && !row_last)
        |=> (row_q == $past(row_q) + RW'(1)) && (col_q == '0));

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (run_q && start && !tap_last) |=> (tap_q == $past(tap_q) + TW'(1)));
endmodule

// File: rtl/conv_window_mac.sv
module conv_window_mac
    import conv_pkg::*;
#(
    parameter int NF = 4,
    parameter int RW = 2,
    parameter int CW = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  tap_ctl_t             stg_ctl,
    input  logic [RW-1:0]        stg_row,
    input  logic [CW-1:0]        stg_col,
    input  fx_t                  pix,
    input  logic [NF*DATA_W-1:0] w_flat,
    input  logic [NF*DATA_W-1:0] b_flat,
    output logic                 out_valid,
    output logic                 out_final,
    output logic [RW-1:0]        out_row,
    output logic [CW-1:0]        out_col,
    output logic [NF*DATA_W-1:0] out_data
);
    logic          vld_q, fin_q;
    logic [RW-1:0] row_q;
    logic [CW-1:0] col_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            fin_q <= 1'b0;
            row_q <= '0;
            col_q <= '0;
        end else begin
            vld_q <= stg_ctl.valid && stg_ctl.last;
            fin_q <= stg_ctl.valid && stg_ctl.final_pos;
            if (stg_ctl.valid && stg_ctl.last) begin
                row_q <= stg_row;
                col_q <= stg_col;
            end
        end
    end

    for (genvar f = 0; f < NF; f++) begin : g_acc
        fx_t                 w_f, b_f;
        logic signed [31:0]  prod;
        wide_t               base, sum, acc_q;
        fx_t                 res_q;

        assign w_f  = w_flat[f*DATA_W +: DATA_W];
        assign b_f  = b_flat[f*DATA_W +: DATA_W];
        assign prod = pix * w_f;
        assign base = stg_ctl.first ? bias_align(b_f) : acc_q;
        assign sum  = base + wide_t'(prod);

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q <= '0;
                res_q <= '0;
            end else if (stg_ctl.valid) begin
                acc_q <= sum;
                if (stg_ctl.last) res_q <= sat_fx(sum);
            end
        end

        assign out_data[f*DATA_W +: DATA_W] = res_q;
    end

    assign out_valid = vld_q;
    assign out_final = fin_q;
    assign out_row   = row_q;
    assign out_col   = col_q;

    p_final_is_beat_r9: assert property (@(posedge clk) disable iff (rst)
        out_final |-> out_valid);
endmodule

// File: rtl/conv_layer_engine.sv
module conv_layer_engine
    import conv_pkg::*;
#(
    parameter int IH = 6,
    parameter int IW = 6,
    parameter int CH = 2,
    parameter int K  = 3,
    parameter int NF = 4,
    localparam int OH   = IH - K + 1,
    localparam int OW   = IW - K + 1,
    localparam int TAPS = CH * K * K,
    localparam int AW   = wid(CH * IH * IW),
    localparam int FW   = wid(NF),
    localparam int TW   = $clog2(TAPS + 1),
    localparam int RW   = wid(OH),
    localparam int CW   = wid(OW)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 img_we,
    input  logic [AW-1:0]        img_addr,
    input  logic [15:0]          img_wdata,
    input  logic                 coef_we,
    input  logic [FW-1:0]        coef_filt,
    input  logic [TW-1:0]        coef_addr,
    input  logic [15:0]          coef_wdata,
    output logic                 busy,
    output logic                 done,
    output logic                 out_valid,
    output logic [RW-1:0]        out_row,
    output logic [CW-1:0]        out_col,
    output logic [NF*DATA_W-1:0] out_data
);
    tap_ctl_t      iss_ctl, stg_ctl;
    logic [RW-1:0] iss_row, stg_row;
    logic [CW-1:0] iss_col, stg_col;
    logic [TW-1:0] iss_tap, stg_tap;
    logic [AW-1:0] iss_addr;
    fx_t           pix;
    logic [NF*DATA_W-1:0] w_flat, b_flat;
    logic          out_final;
    logic          done_q;

    conv_sched #(.IH(IH), .IW(IW), .CH(CH), .K(K)) u_sched (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .done_i   (done_q),
        .busy     (busy),
        .iss_ctl  (iss_ctl),
        .iss_row  (iss_row),
        .iss_col  (iss_col),
        .iss_tap  (iss_tap),
        .iss_addr (iss_addr)
    );

    conv_fmap_mem #(.DEPTH(CH * IH * IW)) u_fmap (
        .clk   (clk),
        .we    (img_we),
        .waddr (img_addr),
        .wdata (fx_t'(img_wdata)),
        .raddr (iss_addr),
        .rdata (pix)
    );

    // align tap control with the one-cycle image read
    always_ff @(posedge clk) begin
        if (rst) begin
            stg_ctl <= '0;
            stg_row <= '0;
            stg_col <= '0;
            stg_tap <= '0;
        end else begin
            stg_ctl <= iss_ctl;
            stg_row <= iss_row;
            stg_col <= iss_col;
            stg_tap <= iss_tap;
        end
    end

    conv_coef_bank #(.NF(NF), .TAPS(TAPS)) u_coef (
        .clk    (clk),
        .rst    (rst),
        .we     (coef_we),
        .filt   (coef_filt),
        .addr   (coef_addr),
        .wdata  (fx_t'(coef_wdata)),
        .rd_tap (stg_tap),
        .w_flat (w_flat),
        .b_flat (b_flat)
    );

    conv_window_mac #(.NF(NF), .RW(RW), .CW(CW)) u_mac (
        .clk       (clk),
        .rst       (rst),
        .stg_ctl   (stg_ctl),
        .stg_row   (stg_row),
        .stg_col   (stg_col),
        .pix       (pix),
        .w_flat    (w_flat),
        .b_flat    (b_flat),
        .out_valid (out_valid),
        .out_final (out_final),
        .out_row   (out_row),
        .out_col   (out_col),
        .out_data  (out_data)
    );

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= out_valid && out_final;
    end

    assign done = done_q;

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_idle_after_done_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    p_beat_in_pass_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy);

    p_done_in_pass_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
endmodule

// File: tb/conv_layer_engine_bench.sv
module conv_layer_engine_bench;
    localparam int IH = 6, IW = 6, CH = 2, K = 3, NF = 4;
    localparam int OH = IH - K + 1, OW = IW - K + 1;
    localparam int TAPS = CH * K * K;
    localparam int DEPTH = CH * IH * IW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic img_we = 1'b0;
    logic [6:0] img_addr = '0;
    logic [15:0] img_wdata = '0;
    logic coef_we = 1'b0;
    logic [1:0] coef_filt = '0;
    logic [4:0] coef_addr = '0;
    logic [15:0] coef_wdata = '0;
    logic busy, done, out_valid;
    logic [1:0] out_row, out_col;
    logic [NF*16-1:0] out_data;

    always #10 clk = ~clk;

    conv_layer_engine u_conv_layer_engine (
        .clk(clk), .rst(rst), .start(start),
        .img_we(img_we), .img_addr(img_addr), .img_wdata(img_wdata),
        .coef_we(coef_we), .coef_filt(coef_filt), .coef_addr(coef_addr),
        .coef_wdata(coef_wdata),
        .busy(busy), .done(done), .out_valid(out_valid),
        .out_row(out_row), .out_col(out_col), .out_data(out_data)
    );

    int img [DEPTH];
    int wt  [NF][TAPS];
    int bs  [NF];
    int n_chk = 0, n_fail = 0;
    int unsigned seed = 32'h1234_5678;
    int cyc = 0;
    bit finished = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d exp %0d", tag, got, exp);
        end
    endtask

    function automatic int rnd(int span);
        seed = seed * 1103515245 + 12345;
        return int'((seed >> 8) % span) - span / 2;
    endfunction

    function automatic int model(int f, int r, int c);
        longint acc;
        acc = longint'(bs[f]) <<< 8;
        for (int ch = 0; ch < CH; ch++)
            for (int kr = 0; kr < K; kr++)
                for (int kc = 0; kc < K; kc++)
                    acc += longint'(img[(ch*IH + r + kr)*IW + c + kc])
                         * longint'(wt[f][(ch*K + kr)*K + kc]);
        acc = acc >>> 8;
        if (acc > 32767) acc = 32767;
        if (acc < -32768) acc = -32768;
        return int'(acc);
    endfunction

    task automatic load_all();
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            img_we = 1; img_addr = 7'(a); img_wdata = 16'(img[a]);
        end
        for (int f = 0; f < NF; f++)
            for (int t = 0; t <= TAPS; t++) begin
                @(negedge clk);
                img_we = 0;
                coef_we = 1; coef_filt = 2'(f); coef_addr = 5'(t);
                coef_wdata = (t == TAPS) ? 16'(bs[f]) : 16'(wt[f][t]);
            end
        @(negedge clk);
        img_we = 0; coef_we = 0;
    endtask

    task automatic run_pass(string tag, bit stray_start);
        int er = 0, ec = 0, nout = 0, last_cyc = -10, k = 0;
        bit seen_done = 0;
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        check("R2 busy after start", int'(busy), 1);
        while (!seen_done && k < 2000) begin
            k++;
            if (stray_start && k == 40) start = 1;
            else start = 0;
            if (out_valid) begin
                check("R3 row order", int'(out_row), er);
                check("R3 col order", int'(out_col), ec);
                for (int f = 0; f < NF; f++)
                    check({tag, " R6 filter value"},
                          int'($signed(out_data[f*16 +: 16])), model(f, er, ec));
                nout++;
                last_cyc = k;
                if (ec == OW - 1) begin ec = 0; er++; end else ec++;
            end
            if (done) begin
                seen_done = 1;
                check("R9 done one cycle after last beat", k, last_cyc + 1);
                check("R3 beat count", nout, OH * OW);
                check("R2 busy during done", int'(busy), 1);
            end
            @(negedge clk);
        end
        start = 0;
        check("R9 done seen", int'(seen_done), 1);
        check("R9 done single", int'(done), 0);
        check("R2 idle after done", int'(busy), 0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (out_valid || busy) begin
                check("R10 no beats after pass", 1, 0);
                break;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy reset", int'(busy), 0);
        check("R1 done reset", int'(done), 0);
        check("R1 valid reset", int'(out_valid), 0);
        rst = 0;

        // pseudo-random mixed-sign operands: R4/R5 addressing, shift
        for (int a = 0; a < DEPTH; a++) img[a] = rnd(1024);
        for (int f = 0; f < NF; f++) begin
            for (int t = 0; t < TAPS; t++) wt[f][t] = rnd(256);
            bs[f] = rnd(2048);
        end
        load_all();
        run_pass("R5 R4 random", 0);

        // stray start mid-pass must not restart: R10
        run_pass("R10 stray start", 1);

        // bias only: R7 seeding per position, no carry-over
        for (int f = 0; f < NF; f++) begin
            for (int t = 0; t < TAPS; t++) wt[f][t] = 0;
            bs[f] = (f == 3) ? -32768 : (f * 1000 - 1234);
        end
        load_all();
        run_pass("R7 bias only", 0);

        // full scale, even filters positive, odd negative: R8
        for (int a = 0; a < DEPTH; a++) img[a] = 32767;
        for (int f = 0; f < NF; f++) begin
            for (int t = 0; t < TAPS; t++) wt[f][t] = (f % 2 == 0) ? 32767 : -32768;
            bs[f] = 0;
        end
        load_all();
        run_pass("R8 saturate", 0);

        // identity tap on centre of channel f%2: each value = pixel + bias
        for (int a = 0; a < DEPTH; a++) img[a] = a * 301 - 9000;
        for (int f = 0; f < NF; f++) begin
            for (int t = 0; t < TAPS; t++) wt[f][t] = 0;
            wt[f][((f % 2)*K + 1)*K + 1] = 256;
            bs[f] = 17 * f;
        end
        load_all();
        run_pass("R4 identity", 0);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule